// File: doc/BRIEF.md
# AUX Request Framer and Reply Parser

This block sits between a request source and an auxiliary-channel engine that owns a small bank of five 32-bit data words. A request arrives as a descriptor: a 4-bit command, a 20-bit target address, a length of 0 to 16, and up to 16 payload bytes. The block classifies the command, builds the outgoing byte stream (header plus optional payload), packs it most-significant byte first into data words and writes them one per cycle into the bank. It then starts the channel with the byte count and a key-append flag.

When the channel reports completion with a received byte count, the block reads back only as many words as it needs. It clamps the count to the size it expected, decodes the reply code, and produces either a short-write count (write class) or a payload with the leading reply byte removed (read class). Malformed requests, oversize requests and impossible reply sizes end early with a status code, and nothing further is touched.

The channel's line signalling, bit coding and retry policy live elsewhere. The block handles one request at a time.

Top module: `aux_frame_codec`

## Requirements
- R1: Stream byte 0 is {cmd[3:0], addr[19:16]}, byte 1 is addr[15:8], byte 2 is addr[7:0], and byte 3 is len-1. Stream byte 4k+m goes to bits 31-8m down to 24-8m of data word k, and words are written at indices 0, 1, 2 and so on, in that order.
- R2: A zero-length request has a transmit size of 3. One word is written, and its low byte is zero.
- R3: A write of length n>0 has a transmit size of 4+n. Payload byte j (req_wdata[8j+7:8j]) is stream byte 4+j. A partial last word has zero low bytes, and length 16 fills all five words.
- R4: A read of length n>0 has a transmit size of 4, and exactly one word is written.
- R5: A length above 16 ends with status 2 (too big). No word is written and the channel is not started.
- R6: Command class ignores cmd bit 2. With bit 2 cleared, values 8, 0 and 2 are writes and values 9 and 1 are reads. Any other value ends with status 1 (invalid), with no word written and no start.
- R7: xfer_key is 1 exactly when the command with bit 2 cleared equals 8 and the address equals KEY_ADDR (default 20'h68007).
- R8: res_reply is the upper nibble of the first received byte.
- R9: For a write, if the usable received count is at least 2, res_count is min(second byte, len). Otherwise res_count is len.
- R10: The usable count is min(received count, expected), where the expected count is 2 for writes and len+1 for reads. For a read, res_count is the usable count minus 1, res_data byte j (bits 8j+7:8j) is received byte j+1 for j below res_count, and the other res_data bytes are zero.
- R11: A received count of 0 or above 20 ends with status 3. Every non-zero status reports res_count 0.
- R12: The block reads ceil(usable/4) words, with rd_data taken one cycle after rd_en. req_ready is low from acceptance until the result. A success reports status 0.
- R13: After reset, req_ready is 1, and wr_en, xfer_start, rd_en and res_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request descriptor valid |
| req_ready | output | 1 | Block idle and able to accept |
| req_cmd | input | 4 | Command nibble |
| req_addr | input | 20 | Target address |
| req_len | input | LEN_W | Request length |
| req_wdata | input | MAX_PAY*8 | Write payload, byte j at bits 8j+7:8j |
| wr_en | output | 1 | Data word write strobe |
| wr_idx | output | IDX_W | Data word index |
| wr_data | output | 32 | Packed data word |
| xfer_start | output | 1 | Start the channel (one-cycle pulse) |
| xfer_tx_bytes | output | CNT_W | Bytes to transmit |
| xfer_key | output | 1 | Append hardware key bytes after header |
| xfer_done | input | 1 | Channel finished |
| xfer_rx_bytes | input | CNT_W | Bytes received by the channel |
| rd_en | output | 1 | Data word read strobe |
| rd_idx | output | IDX_W | Data word read index |
| rd_data | input | 32 | Read word, valid one cycle after rd_en |
| res_valid | output | 1 | Result pulse |
| res_status | output | 2 | 0 ok, 1 invalid, 2 too big, 3 bad reply size |
| res_reply | output | 4 | Reply code |
| res_count | output | CNT_W | Short-write count or read payload length |
| res_data | output | MAX_PAY*8 | Read payload |

## Verification
A wrong word counter or index shows at the bank within the transmit phase: a missing, repeated or misordered word is visible before xfer_start fires. A wrong state after completion shows as a wrong number of rd_en pulses, or as a result that mixes bytes from the wrong word, one to four cycles after xfer_done. A stuck state keeps req_ready low and withholds res_valid. Error paths are judged by the absence of any bank write or start, together with the status and the zero count in the very next result.

// File: rtl/aux_codec_pkg.sv
package aux_codec_pkg;
  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_INVALID = 2'd1,
    ST_TOOBIG  = 2'd2,
    ST_BADRX   = 2'd3
  } res_status_e;

  typedef enum logic [1:0] {CL_NONE, CL_WRITE, CL_READ} cmd_class_e;

  typedef enum logic [2:0] {
    S_IDLE, S_EVAL, S_TX, S_GO, S_WAIT, S_RD, S_DRAIN, S_DONE
  } fsm_e;

  // Bit 2 is the continuation flag and never changes the class.
  function automatic cmd_class_e classify(input logic [3:0] c);
    case (c & 4'b1011)
      4'h8, 4'h0, 4'h2: classify = CL_WRITE;
      4'h9, 4'h1:       classify = CL_READ;
      default:          classify = CL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/aux_tx_pack.sv
module aux_tx_pack
  import aux_codec_pkg::*;
#(
  parameter int          WORDS    = 5,
  parameter int          MAX_PAY  = 16,
  parameter int          LEN_W    = 5,
  parameter logic [19:0] KEY_ADDR = 20'h68007,
  localparam int BYTES = WORDS * 4,
  localparam int CNT_W = $clog2(BYTES + 1),
  localparam int NW_W  = $clog2(WORDS) + 1
) (
  input  logic [3:0]           cmd,
  input  logic [19:0]          addr,
  input  logic [LEN_W-1:0]     len,
  input  logic [MAX_PAY*8-1:0] wdata,
  output cmd_class_e           cls,
  output logic                 too_big,
  output logic                 key,
  output logic [CNT_W-1:0]     tx_bytes,
  output logic [CNT_W-1:0]     rx_exp,
  output logic [NW_W-1:0]      n_words,
  output logic [31:0]          words [WORDS]
);
  localparam int SLOTS = (MAX_PAY < BYTES - 4) ? MAX_PAY : BYTES - 4;

  logic [7:0] sb [BYTES];
  int tx_i, rx_i, len_i;

  always_comb begin
    len_i = int'(len);
    cls   = classify(cmd);
    key   = ((cmd & 4'b1011) == 4'h8) && (addr == KEY_ADDR);
    if (len_i == 0)          tx_i = 3;
    else if (cls == CL_WRITE) tx_i = 4 + len_i;
    else                      tx_i = 4;
    rx_i    = (cls == CL_WRITE) ? 2 : len_i + 1;
    too_big = (len_i > MAX_PAY) || (tx_i > BYTES) || (rx_i > BYTES);
    for (int i = 0; i < BYTES; i++) sb[i] = 8'h00;
    sb[0] = {cmd, addr[19:16]};
    sb[1] = addr[15:8];
    sb[2] = addr[7:0];
    if (len_i != 0) sb[3] = 8'(len_i - 1);
    if (cls == CL_WRITE)
      for (int j = 0; j < SLOTS; j++)
        if (j < len_i) sb[4+j] = wdata[8*j +: 8];
    for (int i = 0; i < BYTES; i++)
      if (i >= tx_i) sb[i] = 8'h00;
    tx_bytes = CNT_W'(tx_i);
    rx_exp   = CNT_W'(rx_i);
    n_words  = NW_W'((tx_i + 3) / 4);
  end

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    assign words[k] = {sb[4*k], sb[4*k+1], sb[4*k+2], sb[4*k+3]};
  end
endmodule

// File: rtl/aux_rx_unpack.sv
module aux_rx_unpack
  import aux_codec_pkg::*;
#(
  parameter int WORDS   = 5,
  parameter int MAX_PAY = 16,
  parameter int LEN_W   = 5,
  localparam int BYTES = WORDS * 4,
  localparam int CNT_W = $clog2(BYTES + 1)
) (
  input  logic [31:0]          rx_words [WORDS],
  input  logic [CNT_W-1:0]     rcv,
  input  cmd_class_e           cls,
  input  logic [LEN_W-1:0]     len,
  output logic [3:0]           reply,
  output logic [CNT_W-1:0]     count,
  output logic [MAX_PAY*8-1:0] data
);
  localparam int SLOTS = (MAX_PAY < BYTES - 1) ? MAX_PAY : BYTES - 1;

  logic [7:0] rb [BYTES];
  int rcv_i, len_i, cnt_i;

  for (genvar k = 0; k < WORDS; k++) begin : g_w
    for (genvar m = 0; m < 4; m++) begin : g_b
      assign rb[4*k+m] = rx_words[k][31-8*m -: 8];
    end
  end

  always_comb begin
    rcv_i = int'(rcv);
    len_i = int'(len);
    reply = rb[0][7:4];
    data  = '0;
    if (cls == CL_WRITE) begin
      if (rcv_i > 1) cnt_i = (int'(rb[1]) > len_i) ? len_i : int'(rb[1]);
      else           cnt_i = len_i;
    end else begin
      cnt_i = (rcv_i > 0) ? rcv_i - 1 : 0;
      for (int j = 0; j < SLOTS; j++)
        if (j < cnt_i) data[8*j +: 8] = rb[1+j];
    end
    count = CNT_W'(cnt_i);
  end
endmodule

// File: rtl/aux_frame_codec.sv
module aux_frame_codec
  import aux_codec_pkg::*;
#(
  parameter int          WORDS    = 5,
  parameter int          MAX_PAY  = 16,
  parameter int          LEN_W    = 5,
  parameter logic [19:0] KEY_ADDR = 20'h68007,
  localparam int BYTES = WORDS * 4,
  localparam int CNT_W = $clog2(BYTES + 1),
  localparam int IDX_W = $clog2(WORDS),
  localparam int NW_W  = IDX_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [3:0]           req_cmd,
  input  logic [19:0]          req_addr,
  input  logic [LEN_W-1:0]     req_len,
  input  logic [MAX_PAY*8-1:0] req_wdata,
  output logic                 wr_en,
  output logic [IDX_W-1:0]     wr_idx,
  output logic [31:0]          wr_data,
  output logic                 xfer_start,
  output logic [CNT_W-1:0]     xfer_tx_bytes,
  output logic                 xfer_key,
  input  logic                 xfer_done,
  input  logic [CNT_W-1:0]     xfer_rx_bytes,
  output logic                 rd_en,
  output logic [IDX_W-1:0]     rd_idx,
  input  logic [31:0]          rd_data,
  output logic                 res_valid,
  output logic [1:0]           res_status,
  output logic [3:0]           res_reply,
  output logic [CNT_W-1:0]     res_count,
  output logic [MAX_PAY*8-1:0] res_data
);
  fsm_e                 state;
  logic [3:0]           cmd_q;
  logic [19:0]          addr_q;
  logic [LEN_W-1:0]     len_q;
  logic [MAX_PAY*8-1:0] wdata_q;
  logic [NW_W-1:0]      k;
  logic [CNT_W-1:0]     rcv_q;
  logic                 rd_en_d;
  logic [IDX_W-1:0]     rd_idx_d;
  logic [31:0]          rx_buf [WORDS];

  cmd_class_e           cls;
  logic                 too_big, key;
  logic [CNT_W-1:0]     tx_bytes, rx_exp, u_count;
  logic [NW_W-1:0]      n_words, n_rd;
  logic [31:0]          words [WORDS];
  logic [3:0]           u_reply;
  logic [MAX_PAY*8-1:0] u_data;
  logic [IDX_W-1:0]     k_idx;

  assign req_ready = (state == S_IDLE);
  assign k_idx     = k[IDX_W-1:0];
  assign n_rd      = NW_W'((int'(rcv_q) + 3) / 4);

  aux_tx_pack #(.WORDS(WORDS), .MAX_PAY(MAX_PAY), .LEN_W(LEN_W), .KEY_ADDR(KEY_ADDR)) u_pack (
    .cmd(cmd_q), .addr(addr_q), .len(len_q), .wdata(wdata_q),
    .cls(cls), .too_big(too_big), .key(key), .tx_bytes(tx_bytes),
    .rx_exp(rx_exp), .n_words(n_words), .words(words)
  );

  aux_rx_unpack #(.WORDS(WORDS), .MAX_PAY(MAX_PAY), .LEN_W(LEN_W)) u_unpack (
    .rx_words(rx_buf), .rcv(rcv_q), .cls(cls), .len(len_q),
    .reply(u_reply), .count(u_count), .data(u_data)
  );

  // Receive word store: no reset, single write port.
  always_ff @(posedge clk) begin
    if (rd_en_d) rx_buf[rd_idx_d] <= rd_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cmd_q <= '0; addr_q <= '0; len_q <= '0; wdata_q <= '0;
      k <= '0; rcv_q <= '0; rd_en_d <= 1'b0; rd_idx_d <= '0;
      wr_en <= 1'b0; wr_idx <= '0; wr_data <= '0;
      xfer_start <= 1'b0; xfer_tx_bytes <= '0; xfer_key <= 1'b0;
      rd_en <= 1'b0; rd_idx <= '0;
      res_valid <= 1'b0; res_status <= '0; res_reply <= '0;
      res_count <= '0; res_data <= '0;
    end else begin
      wr_en      <= 1'b0;
      xfer_start <= 1'b0;
      rd_en      <= 1'b0;
      res_valid  <= 1'b0;
      rd_en_d    <= rd_en;
      rd_idx_d   <= rd_idx;
      case (state)
        S_IDLE: if (req_valid) begin
          cmd_q <= req_cmd; addr_q <= req_addr;
          len_q <= req_len; wdata_q <= req_wdata;
          state <= S_EVAL;
        end
        S_EVAL: begin
          k <= '0;
          if (cls == CL_NONE || too_big) begin
            res_valid  <= 1'b1;
            res_status <= (cls == CL_NONE) ? ST_INVALID : ST_TOOBIG;
            res_reply  <= '0; res_count <= '0; res_data <= '0;
            state      <= S_IDLE;
          end else begin
            state <= S_TX;
          end
        end
        S_TX: begin
          wr_en   <= 1'b1;
          wr_idx  <= k_idx;
          wr_data <= words[k_idx];
          if (k + 1'b1 == n_words) state <= S_GO;
          else                     k <= k + 1'b1;
        end
        S_GO: begin
          xfer_start    <= 1'b1;
          xfer_tx_bytes <= tx_bytes;
          xfer_key      <= key;
          state         <= S_WAIT;
        end
        S_WAIT: if (xfer_done) begin
          k <= '0;
          if (xfer_rx_bytes == '0 || int'(xfer_rx_bytes) > BYTES) begin
            res_valid  <= 1'b1;
            res_status <= ST_BADRX;
            res_reply  <= '0; res_count <= '0; res_data <= '0;
            state      <= S_IDLE;
          end else begin
            rcv_q <= (xfer_rx_bytes > rx_exp) ? rx_exp : xfer_rx_bytes;
            state <= S_RD;
          end
        end
        S_RD: begin
          rd_en  <= 1'b1;
          rd_idx <= k_idx;
          if (k + 1'b1 == n_rd) state <= S_DRAIN;
          else                  k <= k + 1'b1;
        end
        S_DRAIN: if (!rd_en && !rd_en_d) state <= S_DONE;
        S_DONE: begin
          res_valid  <= 1'b1;
          res_status <= ST_OK;
          res_reply  <= u_reply;
          res_count  <= u_count;
          res_data   <= u_data;
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aux_frame_codec_chk.sv
module aux_frame_codec_chk #(
  parameter int WORDS   = 5,
  parameter int MAX_PAY = 16,
  parameter int CNT_W   = 5,
  parameter int IDX_W   = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             req_ready,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic             xfer_start,
  input logic             rd_en,
  input logic             res_valid,
  input logic [1:0]       res_status,
  input logic [CNT_W-1:0] res_count
);
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!wr_en && !xfer_start && !rd_en));

  a_r3_word_in_bank: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (int'(wr_idx) < WORDS));

  a_r7_start_pulse: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> !xfer_start);

  a_r11_error_zero_count: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_status != 2'd0) |-> (res_count == '0));

  a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (int'(res_count) <= MAX_PAY));

  a_r12_single_result: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
endmodule

bind aux_frame_codec aux_frame_codec_chk #(
  .WORDS(WORDS), .MAX_PAY(MAX_PAY), .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .wr_en(wr_en),
  .wr_idx(wr_idx), .xfer_start(xfer_start), .rd_en(rd_en),
  .res_valid(res_valid), .res_status(res_status), .res_count(res_count)
);

// File: tb/aux_frame_codec_bench.sv
module aux_frame_codec_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [3:0]   req_cmd = '0;
  logic [19:0]  req_addr = '0;
  logic [4:0]   req_len = '0;
  logic [127:0] req_wdata = '0;
  logic         wr_en;
  logic [2:0]   wr_idx;
  logic [31:0]  wr_data;
  logic         xfer_start;
  logic [4:0]   xfer_tx_bytes;
  logic         xfer_key;
  logic         xfer_done = 1'b0;
  logic [4:0]   xfer_rx_bytes = '0;
  logic         rd_en;
  logic [2:0]   rd_idx;
  logic [31:0]  rd_data = '0;
  logic         res_valid;
  logic [1:0]   res_status;
  logic [3:0]   res_reply;
  logic [4:0]   res_count;
  logic [127:0] res_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  aux_frame_codec u_aux_frame_codec (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .xfer_start(xfer_start), .xfer_tx_bytes(xfer_tx_bytes), .xfer_key(xfer_key),
    .xfer_done(xfer_done), .xfer_rx_bytes(xfer_rx_bytes),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
    .res_valid(res_valid), .res_status(res_status), .res_reply(res_reply),
    .res_count(res_count), .res_data(res_data)
  );

  int total = 0, fails = 0;
  int wr_cnt = 0, start_cnt = 0, rd_cnt = 0;
  logic [31:0] bank [5];
  logic [31:0] rw [5];
  logic [4:0]  s_tx;
  logic        s_key;
  logic [7:0]  eb [20];
  int          etx;
  // results of the last transaction
  logic [1:0]   r_status;
  logic [3:0]   r_reply;
  logic [4:0]   r_count;
  logic [127:0] r_data;
  int           d_wr, d_start, d_rd;

  // channel model
  always @(posedge clk) begin
    if (wr_en) begin bank[wr_idx] <= wr_data; wr_cnt <= wr_cnt + 1; end
    if (xfer_start) begin start_cnt <= start_cnt + 1; s_tx <= xfer_tx_bytes; s_key <= xfer_key; end
    if (rd_en) begin rd_data <= rw[rd_idx]; rd_cnt <= rd_cnt + 1; end
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // expected outgoing stream from the requirements
  task automatic build_exp(input logic [3:0] c, input logic [19:0] a, input int n,
                           input logic [127:0] wd, input bit is_wr);
    for (int i = 0; i < 20; i++) eb[i] = 8'h00;
    eb[0] = {c, a[19:16]}; eb[1] = a[15:8]; eb[2] = a[7:0];
    if (n == 0) etx = 3;
    else begin
      eb[3] = 8'(n - 1);
      etx = is_wr ? 4 + n : 4;
      if (is_wr) for (int j = 0; j < n; j++) eb[4+j] = wd[8*j +: 8];
    end
  endtask

  function automatic logic [31:0] exp_word(input int k);
    return {eb[4*k], eb[4*k+1], eb[4*k+2], eb[4*k+3]};
  endfunction

  task automatic check_stream(input string tag);
    chk({tag, " tx bytes"}, 128'(s_tx), 128'(etx));
    chk({tag, " words"}, 128'(d_wr), 128'((etx + 3) / 4));
    for (int k = 0; k < (etx + 3) / 4; k++)
      chk({tag, " word"}, 128'(bank[k]), 128'(exp_word(k)));
  endtask

  task automatic do_req(input logic [3:0] c, input logic [19:0] a, input int n,
                        input logic [127:0] wd, input int rxn);
    int ws, ss, rs, guard;
    bit got, sent;
    ws = wr_cnt; ss = start_cnt; rs = rd_cnt;
    @(negedge clk);
    req_cmd = c; req_addr = a; req_len = 5'(n); req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 ready low while busy", 128'(req_ready), 128'(0));
    got = 0; sent = 0; guard = 0;
    while (!got && guard < 400) begin
      @(negedge clk);
      guard++;
      xfer_done = 1'b0;
      if (res_valid) begin
        got = 1;
        r_status = res_status; r_reply = res_reply; r_count = res_count; r_data = res_data;
      end else if (!sent && start_cnt != ss) begin
        xfer_rx_bytes = 5'(rxn); xfer_done = 1'b1; sent = 1;
      end
    end
    xfer_done = 1'b0;
    if (!got) chk("R12 result arrives", 128'(0), 128'(1));
    d_wr = wr_cnt - ws; d_start = start_cnt - ss; d_rd = rd_cnt - rs;
  endtask

  function automatic logic [127:0] pay(input int base);
    logic [127:0] v = '0;
    for (int j = 0; j < 16; j++) v[8*j +: 8] = 8'(base + j);
    return v;
  endfunction

  task automatic t_reset;
    chk("R13 ready", 128'(req_ready), 128'(1));
    chk("R13 res_valid", 128'(res_valid), 128'(0));
    chk("R13 wr_en", 128'(wr_en), 128'(0));
    chk("R13 start", 128'(xfer_start), 128'(0));
    chk("R13 rd_en", 128'(rd_en), 128'(0));
  endtask

  task automatic t_write_basic;
    rw[0] = 32'h1003_0000;
    build_exp(4'h8, 20'h12345, 5, pay(8'hA0), 1);
    do_req(4'h8, 20'h12345, 5, pay(8'hA0), 2);
    check_stream("R1 R3 write len5");
    chk("R7 key off", 128'(s_key), 128'(0));
    chk("R8 reply", 128'(r_reply), 128'(1));
    chk("R9 count", 128'(r_count), 128'(3));
    chk("R12 status ok", 128'(r_status), 128'(0));
    chk("R12 reads", 128'(d_rd), 128'(1));
  endtask

  task automatic t_write_short;
    rw[0] = 32'h2000_0000;
    do_req(4'h8, 20'h00001, 5, pay(1), 1);
    chk("R8 reply one byte", 128'(r_reply), 128'(2));
    chk("R9 absent count -> len", 128'(r_count), 128'(5));
    rw[0] = 32'h0030_0000;
    do_req(4'h2, 20'h00001, 5, pay(1), 2);
    chk("R9 clamp to len", 128'(r_count), 128'(5));
  endtask

  task automatic t_read;
    rw[0] = 32'h0011_2233; rw[1] = 32'h4400_0000;
    build_exp(4'h9, 20'h00100, 4, '0, 0);
    do_req(4'h9, 20'h00100, 4, pay(8'h77), 5);
    check_stream("R4 read len4");
    chk("R10 count", 128'(r_count), 128'(4));
    chk("R10 data", r_data, 128'h4433_2211);
    chk("R12 reads two", 128'(d_rd), 128'(2));
    rw[0] = 32'hA055_6677;
    build_exp(4'hD, 20'hABCDE, 2, '0, 0);
    do_req(4'hD, 20'hABCDE, 2, '0, 10);
    check_stream("R6 R4 read with bit2");
    chk("R10 clamp count", 128'(r_count), 128'(2));
    chk("R10 clamp data", r_data, 128'h6655);
    chk("R8 reply A", 128'(r_reply), 128'hA);
    chk("R12 clamp reads", 128'(d_rd), 128'(1));
  endtask

  task automatic t_zero_len;
    rw[0] = 32'h0000_0000;
    build_exp(4'h0, 20'h00050, 0, '0, 1);
    do_req(4'h0, 20'h00050, 0, pay(9), 1);
    check_stream("R2 zero write");
    chk("R9 zero count", 128'(r_count), 128'(0));
    build_exp(4'h1, 20'hF0001, 0, '0, 0);
    do_req(4'h1, 20'hF0001, 0, '0, 3);
    check_stream("R2 zero read");
    chk("R10 zero read count", 128'(r_count), 128'(0));
    chk("R10 zero read data", r_data, 128'h0);
  endtask

  task automatic t_max_write;
    rw[0] = 32'h0010_0000;
    build_exp(4'h8, 20'h0BEEF, 16, pay(8'h30), 1);
    do_req(4'h8, 20'h0BEEF, 16, pay(8'h30), 2);
    check_stream("R3 len16 five words");
    chk("R9 count 16", 128'(r_count), 128'(16));
  endtask

  task automatic t_key;
    rw[0] = 32'h0000_0000;
    build_exp(4'hC, 20'h68007, 5, pay(3), 1);
    do_req(4'hC, 20'h68007, 5, pay(3), 1);
    check_stream("R7 key write stream");
    chk("R7 key set", 128'(s_key), 128'(1));
    do_req(4'h4, 20'h68007, 5, pay(3), 1);
    chk("R7 other write class", 128'(s_key), 128'(0));
    do_req(4'h9, 20'h68007, 5, '0, 6);
    chk("R7 read no key", 128'(s_key), 128'(0));
  endtask

  task automatic t_oversize;
    do_req(4'h8, 20'h00010, 17, pay(0), 2);
    chk("R5 write status", 128'(r_status), 128'(2));
    chk("R5 write no words", 128'(d_wr), 128'(0));
    chk("R5 write no start", 128'(d_start), 128'(0));
    do_req(4'h9, 20'h00010, 20, '0, 2);
    chk("R5 read status", 128'(r_status), 128'(2));
    chk("R5 read no words", 128'(d_wr), 128'(0));
    chk("R11 error count zero", 128'(r_count), 128'(0));
  endtask

  task automatic t_invalid;
    do_req(4'h3, 20'h00010, 2, pay(0), 2);
    chk("R6 status 3", 128'(r_status), 128'(1));
    chk("R6 no words", 128'(d_wr), 128'(0));
    chk("R6 no start", 128'(d_start), 128'(0));
    do_req(4'hE, 20'h00010, 2, pay(0), 2);
    chk("R6 status E", 128'(r_status), 128'(1));
    chk("R6 no words E", 128'(d_wr), 128'(0));
  endtask

  task automatic t_badrx;
    do_req(4'h8, 20'h00020, 2, pay(0), 0);
    chk("R11 rx zero", 128'(r_status), 128'(3));
    chk("R11 rx zero no reads", 128'(d_rd), 128'(0));
    do_req(4'h9, 20'h00020, 2, '0, 21);
    chk("R11 rx 21", 128'(r_status), 128'(3));
    chk("R11 rx 21 count", 128'(r_count), 128'(0));
  endtask

  initial begin
    for (int i = 0; i < 5; i++) begin bank[i] = '0; rw[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write_basic();
    t_write_short();
    t_read();
    t_zero_len();
    t_max_write();
    t_key();
    t_oversize();
    t_invalid();
    t_badrx();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule